// File: doc/BRIEF.md
# Extended Control Register Read Unit

This unit carries out the read of an extended control register for one processor execution stage. A request supplies a 64-bit index value and several control inputs. The control inputs are a lock-prefix flag, a flag that says the feature is present, an operating-system enable bit, and a capability bit for the masked read. The request also supplies the live in-use state bitmap. One cycle later the unit returns two 64-bit destination values with their write enables, or it reports a fault and leaves the destinations alone.

The unit holds the base control register (index 0) itself. A plain write port loads it. Only the bits picked by a parameter mask are stored, and bit 0 always reads as one. Index 1 returns the base register ANDed with the in-use bitmap, but only when the capability bit is set. Faults are checked in two layers. An invalid-opcode fault comes first. A general-protection fault, which always has a zero error code, is raised only when no invalid-opcode condition is present.

Top module: `ext_ctl_read_unit`

## Requirements
- R1: After reset, rsp_valid, rsp_fault, both write enables and both destinations are 0, and a read of index 0 returns 1 in the low destination.
- R2: Only bits [31:0] of req_index select the register. Bits [63:32] have no effect on the response.
- R3: On a successful read, rsp_lo[31:0] holds bits [31:0] of the selected value and rsp_hi[31:0] holds bits [63:32]. Bits [63:32] of both destinations are zero.
- R4: Index 0 returns the base register whenever no fault condition is present.
- R5: Index 1 with inuse_cap=1 returns the base register ANDed with inuse_map.
- R6: Index 1 with inuse_cap=0, or any index other than 0 or 1, raises a general-protection fault, rsp_fault_type=2.
- R7: feat_present=0, os_enable=0 or req_lock=1 raises an invalid-opcode fault, rsp_fault_type=1.
- R8: Invalid-opcode conditions take priority over general-protection conditions. A response never carries both rsp_valid and rsp_fault.
- R9: On a fault, rsp_hi_we and rsp_lo_we are 0 and rsp_hi and rsp_lo keep their previous values.
- R10: An accepted request (req_valid=1) gives exactly one response cycle on the next clock. A cycle without a request gives neither rsp_valid nor rsp_fault on the next clock.
- R11: A write on cfg_we stores cfg_wdata ANDed with the IMPL_MASK parameter (default 0x0000_0006_0000_02FF) with bit 0 forced to 1. A read issued in the cycle after the write sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| req_ready | output | 1 | High when a request can be accepted (outside reset) |
| req_index | input | 64 | Register index; only the low 32 bits are used |
| req_lock | input | 1 | Lock prefix present |
| feat_present | input | 1 | Feature supported |
| os_enable | input | 1 | Operating-system enable control bit |
| inuse_cap | input | 1 | Enables the masked read at index 1 |
| inuse_map | input | 64 | Live in-use state bitmap |
| cfg_we | input | 1 | Base register write enable |
| cfg_wdata | input | 64 | Base register write data |
| rsp_valid | output | 1 | Successful read result |
| rsp_fault | output | 1 | Fault reported |
| rsp_fault_type | output | 2 | 0 none, 1 invalid opcode, 2 general protection |
| rsp_hi | output | 64 | High destination value |
| rsp_lo | output | 64 | Low destination value |
| rsp_hi_we | output | 1 | High destination write enable |
| rsp_lo_we | output | 1 | Low destination write enable |

## Verification
A corrupted base register shows up on the next index 0 read, one cycle after the request. If the corruption is in bit 0 or in a masked bit, it shows even when the written data tries to hide it. A wrong fault priority or a wrong index decode gives the wrong rsp_fault_type, or a stray write enable, on the response cycle itself. A fault that lets the destinations move is visible on the same cycle as a changed rsp_hi or rsp_lo. A broken split or a missing upper clear shows as misplaced bits on the first successful read whose selected value has bits set above bit 31.

// File: rtl/ecr_pkg.sv
package ecr_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } fault_e;

  typedef enum logic {
    SEL_BASE   = 1'b0,
    SEL_MASKED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/ecr_base_reg.sv
module ecr_base_reg #(
  parameter int          DATA_W    = 64,
  parameter logic [63:0] IMPL_MASK = 64'h0000_0006_0000_02FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value
);
  localparam logic [DATA_W-1:0] MASK  = IMPL_MASK[DATA_W-1:0];
  localparam logic [DATA_W-1:0] FORCE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (rst)     store_q <= FORCE;
    else if (we) store_q <= (wdata & MASK) | FORCE;
  end

  assign value = store_q;

  AST_BASE_BIT_SET: assert property (@(posedge clk) disable iff (rst)
    we |=> value[0]) else $error("base bit lost"); // R11
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
    we |=> ((value & ~(MASK | FORCE)) == '0)) else $error("unimplemented bit set"); // R11
endmodule

// File: rtl/ecr_fault_check.sv
module ecr_fault_check
  import ecr_pkg::*;
#(
  parameter int IDX_W = 32
) (
  input  logic [IDX_W-1:0] index,
  input  logic             lock,
  input  logic             feat,
  input  logic             os_en,
  input  logic             cap,
  output fault_e           fault,
  output src_sel_e         sel
);
  localparam logic [IDX_W-1:0] IDX_BASE   = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_MASKED = IDX_W'(1);

  logic ud_cond;
  logic gp_cond;

  always_comb begin
    ud_cond = !feat || !os_en || lock;
    gp_cond = !((index == IDX_BASE) || ((index == IDX_MASKED) && cap));
    if (ud_cond)      fault = FLT_UD;
    else if (gp_cond) fault = FLT_GP;
    else              fault = FLT_NONE;
    sel = (index == IDX_MASKED) ? SEL_MASKED : SEL_BASE;
  end

  AST_NO_FAULT_SEL: assert final ((fault != FLT_NONE) || (index == IDX_BASE) || (index == IDX_MASKED)) else $error("bad index passed"); // R6
endmodule

// File: rtl/ext_ctl_read_unit.sv
module ext_ctl_read_unit
  import ecr_pkg::*;
#(
  parameter int          DATA_W    = 64,
  parameter int          IDX_W     = 32,
  parameter logic [63:0] IMPL_MASK = 64'h0000_0006_0000_02FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_index,
  input  logic              req_lock,
  input  logic              feat_present,
  input  logic              os_enable,
  input  logic              inuse_cap,
  input  logic [DATA_W-1:0] inuse_map,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [1:0]        rsp_fault_type,
  output logic [DATA_W-1:0] rsp_hi,
  output logic [DATA_W-1:0] rsp_lo,
  output logic              rsp_hi_we,
  output logic              rsp_lo_we
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] base_val;
  logic [DATA_W-1:0] sel_val;
  fault_e            chk_fault;
  src_sel_e          chk_sel;
  logic              ready_q;

  ecr_base_reg #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_base (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .value(base_val)
  );

  ecr_fault_check #(.IDX_W(IDX_W)) u_check (
    .index(req_index[IDX_W-1:0]), .lock(req_lock), .feat(feat_present),
    .os_en(os_enable), .cap(inuse_cap), .fault(chk_fault), .sel(chk_sel)
  );

  always_comb begin
    sel_val = (chk_sel == SEL_MASKED) ? (base_val & inuse_map) : base_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q        <= 1'b0;
      rsp_valid      <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_fault_type <= FLT_NONE;
      rsp_hi         <= '0;
      rsp_lo         <= '0;
      rsp_hi_we      <= 1'b0;
      rsp_lo_we      <= 1'b0;
    end else begin
      ready_q        <= 1'b1;
      rsp_valid      <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_fault_type <= FLT_NONE;
      rsp_hi_we      <= 1'b0;
      rsp_lo_we      <= 1'b0;
      if (req_valid && ready_q) begin
        if (chk_fault == FLT_NONE) begin
          rsp_valid <= 1'b1;
          rsp_hi    <= {{(DATA_W-HALF_W){1'b0}}, sel_val[DATA_W-1:HALF_W]};
          rsp_lo    <= {{(DATA_W-HALF_W){1'b0}}, sel_val[HALF_W-1:0]};
          rsp_hi_we <= 1'b1;
          rsp_lo_we <= 1'b1;
        end else begin
          rsp_fault      <= 1'b1;
          rsp_fault_type <= chk_fault;
        end
      end
    end
  end

  assign req_ready = ready_q;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_fault)) else $error("both outcomes"); // R8
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> ($stable(rsp_hi) && $stable(rsp_lo) && !rsp_hi_we && !rsp_lo_we)) else $error("fault moved destinations"); // R9
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hi[DATA_W-1:HALF_W] == '0 && rsp_lo[DATA_W-1:HALF_W] == '0)) else $error("upper half set"); // R3
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_valid || rsp_fault)) else $error("no response"); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(rsp_valid || rsp_fault)) else $error("spurious response"); // R10
  AST_UD_FIRST: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (!feat_present || !os_enable || req_lock)) |=> (rsp_fault && rsp_fault_type == FLT_UD)) else $error("ud missed"); // R7
endmodule

// File: tb/test_ext_ctl_read_unit.sv
module test_ext_ctl_read_unit;
  localparam logic [63:0] MASK = 64'h0000_0006_0000_02FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_index = '0;
  logic        req_lock = 1'b0;
  logic        feat_present = 1'b1;
  logic        os_enable = 1'b1;
  logic        inuse_cap = 1'b0;
  logic [63:0] inuse_map = '0;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic        rsp_valid, rsp_fault, rsp_hi_we, rsp_lo_we;
  logic [1:0]  rsp_fault_type;
  logic [63:0] rsp_hi, rsp_lo;

  int n_checks = 0;
  int n_fail = 0;
  logic [63:0] model_base = 64'h1;
  logic [63:0] last_hi = '0;
  logic [63:0] last_lo = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_ctl_read_unit i_ext_ctl_read_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_lock(req_lock), .feat_present(feat_present),
    .os_enable(os_enable), .inuse_cap(inuse_cap), .inuse_map(inuse_map),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_fault_type(rsp_fault_type), .rsp_hi(rsp_hi),
    .rsp_lo(rsp_lo), .rsp_hi_we(rsp_hi_we), .rsp_lo_we(rsp_lo_we)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(logic [63:0] idx, bit lk, bit ft, bit os, bit cp);
    if (!ft || !os || lk) return 2'd1;
    if (idx[31:0] == 0) return 2'd0;
    if (idx[31:0] == 1 && cp) return 2'd0;
    return 2'd2;
  endfunction

  task automatic write_base(logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_base = (d & MASK) | 64'h1;
  endtask

  task automatic do_read(string req, logic [63:0] idx, bit lk, bit ft, bit os, bit cp, logic [63:0] map);
    logic [1:0]  f;
    logic [63:0] v;
    @(negedge clk);
    req_valid = 1'b1; req_index = idx; req_lock = lk; feat_present = ft;
    os_enable = os; inuse_cap = cp; inuse_map = map;
    @(negedge clk);
    req_valid = 1'b0;
    f = exp_fault(idx, lk, ft, os, cp);
    v = (idx[31:0] == 1) ? (model_base & map) : model_base;
    if (f == 2'd0) begin
      check({req, " ok"}, {126'(rsp_valid), rsp_fault_type}, {126'(1), 2'd0});
      check({req, " data"}, {rsp_hi, rsp_lo}, {32'h0, v[63:32], 32'h0, v[31:0]});
      check({req, " we"}, 128'({rsp_hi_we, rsp_lo_we, rsp_fault}), 128'(3'b110));
      last_hi = {32'h0, v[63:32]}; last_lo = {32'h0, v[31:0]};
    end else begin
      check({req, " fault"}, 128'({rsp_valid, rsp_fault, rsp_fault_type}), 128'({1'b0, 1'b1, f}));
      check({req, " hold R9"}, {rsp_hi, rsp_lo, 3'b0}, {last_hi, last_lo, 3'b0} | 128'({rsp_hi_we, rsp_lo_we, 1'b0}));
    end
    @(negedge clk);
    check({req, " idle R10"}, 128'({rsp_valid, rsp_fault}), 128'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset outputs", {rsp_hi, rsp_lo}, '0);
    check("R1 reset flags", 128'({rsp_valid, rsp_fault, rsp_hi_we, rsp_lo_we}), 128'(0));
    do_read("R1 R4 reset value", 64'h0, 0, 1, 1, 0, '0);
    write_base(64'hFFFF_FFFF_FFFF_FFFE);
    do_read("R11 R3 masked write", 64'h0, 0, 1, 1, 0, '0);
    do_read("R2 upper index ignored", 64'hDEAD_BEEF_0000_0000, 0, 1, 1, 0, '0);
    do_read("R5 masked read", 64'h1, 0, 1, 1, 1, 64'h0000_0004_0000_0081);
    do_read("R2 upper on idx1", 64'h8000_0000_0000_0001, 0, 1, 1, 1, '1);
    do_read("R6 idx1 no cap", 64'h1, 0, 1, 1, 0, '1);
    do_read("R6 idx2", 64'h2, 0, 1, 1, 1, '1);
    do_read("R6 idx high", 64'hFFFF_FFFF, 0, 1, 1, 1, '1);
    do_read("R7 lock", 64'h0, 1, 1, 1, 0, '0);
    do_read("R7 no feature", 64'h0, 0, 0, 1, 0, '0);
    do_read("R7 os off", 64'h0, 0, 1, 0, 0, '0);
    do_read("R8 ud over gp", 64'h5, 1, 1, 1, 0, '0);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] idx;
      int s;
      if ($urandom_range(0, 5) == 0) write_base({$urandom, $urandom});
      s = $urandom_range(0, 3);
      idx = {$urandom, (s == 0) ? 32'h0 : (s == 1) ? 32'h1 : (s == 2) ? 32'h2 : $urandom};
      do_read("R4 R5 R6 R7 R8 random", idx, ($urandom_range(0, 7) == 0),
              ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0),
              $urandom_range(0, 1) == 1, {$urandom, $urandom});
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule